// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the register file of a processor's system control coprocessor. The core reaches it with move-to and move-from transfers. Each transfer carries a primary register number, a secondary register number and two opcode fields. In the same cycle the block reports whether it accepts the transfer, and for an accepted read it drives the register contents. The file holds these registers:

- identification, cache type and TCM size (fixed values);
- the control word;
- data and instruction cache configuration;
- the write buffer control;
- data and instruction permission words;
- a bank of protection region descriptors;
- data and instruction cache lock words;
- data and instruction TCM region words.

Some writes act beyond the register file. The control word drives decoded side-band bits: the read/write mode, the exception vector base and a state-load enable. The data TCM word feeds the memory map with an aligned base. The instruction TCM word is kept but its exported base stays at zero. A dedicated write parks the core in a wait-for-interrupt halt until an interrupt arrives. Writes to region or permission words pulse an update strobe toward the protection checker, which lies outside this block.

Top module: `sysctl_regfile`

## Requirements
- R1: While `user_mode` is high, every transfer is rejected (`accept` low, `rdata` zero) and no register or side-band output changes.
- R2: With primary 0, op1 = 0 and secondary 0, a read returns the cache type for op2 = 1, the TCM size for op2 = 2 and the ID code for any other op2. Writes to this register are rejected.
- R3: After reset the registers hold these values, and all other stored registers are zero:
  - ID 0x41049460, cache type 0x0F0D2112, TCM size 0x00140140;
  - control 0;
  - both permission words 0x22222222;
  - instruction TCM word 0x0000000C, data TCM word 0x0080000A.
- R4: The control word (primary 1) and the write buffer word (primary 3) are reached only when op1, op2 and secondary are all zero. Both read back what was written.
- R5: Primary 2 with op1 = 0 and secondary 0 selects the data cache configuration (op2 = 0) or the instruction cache configuration (op2 = 1). Primary 5 with the same conditions selects the data permission word (op2 = 2) or the instruction permission word (op2 = 3). Other op2 values are rejected.
- R6: Primary 6 with op1 = op2 = 0 reaches region descriptor n through secondary n, for n from 0 to 7. Any other secondary or opcode value is rejected.
- R7: Primary 9 with op1 = 0 selects a word by secondary and op2, as listed below; any other combination is rejected:
  - secondary 0, op2 0: data cache lock;
  - secondary 0, op2 1: instruction cache lock;
  - secondary 1, op2 0: data TCM region;
  - secondary 1, op2 1: instruction TCM region.
- R8: From the cycle after a control write, the side-band outputs follow the written word:
  - `ctl_rw_mode` equals bit 7;
  - `vec_base` is 0x0FFF0000 when bit 13 is set and zero otherwise;
  - `state_load_en` is the inverse of bit 15.
- R9: `dtcm_base` equals the stored data TCM word ANDed with 0xFFFFFFC0, and it changes in the cycle after a write. A write to the instruction TCM word is stored and reads back, while `itcm_base` stays zero.
- R10: A write to primary 7 with secondary 0, op1 = 0 and op2 = 4 has two effects from the next cycle on:
  - `halt_req` rises and stays high until `irq` is sampled high at a clock edge; it is low in the cycle after that edge;
  - `irq_master_en` goes high and stays high.

  A read of this encoding is rejected.
- R11: Any encoding not listed above is rejected with `rdata` zero. `accept` and read data are valid in the same cycle as `req_valid`.
- R12: An accepted write to a region descriptor or a permission word makes `prot_update` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request this cycle |
| req_write | input | 1 | 1 = move to coprocessor, 0 = move from |
| user_mode | input | 1 | Requesting core is in unprivileged mode |
| prim_sel | input | 4 | Primary register number |
| sec_sel | input | 4 | Secondary register number |
| op1 | input | 3 | First opcode field |
| op2 | input | 3 | Second opcode field |
| wdata | input | 32 | Write data |
| irq | input | 1 | Interrupt pending, ends the wait state |
| accept | output | 1 | Transfer accepted (combinational) |
| rdata | output | 32 | Read data, zero unless an accepted read |
| ctl_rw_mode | output | 1 | Control bit 7 |
| vec_base | output | 32 | Exception vector base |
| state_load_en | output | 1 | Inverse of control bit 15 |
| dtcm_base | output | 32 | Aligned data TCM base for the memory map |
| itcm_base | output | 32 | Instruction TCM base, always zero |
| halt_req | output | 1 | Wait-for-interrupt halt request |
| irq_master_en | output | 1 | Interrupt master enable, set on wait entry |
| prot_update | output | 1 | One-cycle strobe after a region or permission write |

## Verification
`accept` and `rdata` are combinational, so the bench checks them a short delay after it drives a request, before the clock edge that commits it. The other results are registered and become visible exactly one edge after the transfer or the `irq` sample that causes them. These are the control-derived outputs, `dtcm_base`, `halt_req`, `irq_master_en` and `prot_update`. The bench updates its reference model at that edge and compares every side-band output at the following falling edge, on every cycle. A change in timing therefore shows up as a mismatch in the first cycle where it occurs.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [3:0] {
      RID_NONE   = 4'd0,
      RID_ID     = 4'd1,
      RID_CTYPE  = 4'd2,
      RID_TCMSZ  = 4'd3,
      RID_CTRL   = 4'd4,
      RID_DCCFG  = 4'd5,
      RID_ICCFG  = 4'd6,
      RID_WBUF   = 4'd7,
      RID_DPERM  = 4'd8,
      RID_IPERM  = 4'd9,
      RID_REGION = 4'd10,
      RID_DLOCK  = 4'd11,
      RID_ILOCK  = 4'd12,
      RID_DTCM   = 4'd13,
      RID_ITCM   = 4'd14,
      RID_WFI    = 4'd15
   } reg_id_e;

   localparam logic [31:0] DEF_ID_CODE    = 32'h4104_9460;
   localparam logic [31:0] DEF_CACHE_TYPE = 32'h0F0D_2112;
   localparam logic [31:0] DEF_TCM_SIZE   = 32'h0014_0140;
   localparam logic [31:0] DEF_PERM       = 32'h2222_2222;
   localparam logic [31:0] DEF_ITCM       = 32'h0000_000C;
   localparam logic [31:0] DEF_DTCM       = 32'h0080_000A;
   localparam logic [31:0] DEF_VEC_HIGH   = 32'h0FFF_0000;

   function automatic logic id_read_only(input reg_id_e id);
      return (id == RID_ID) || (id == RID_CTYPE) || (id == RID_TCMSZ);
   endfunction

   function automatic logic id_write_only(input reg_id_e id);
      return (id == RID_WFI);
   endfunction

   function automatic logic id_protection(input reg_id_e id);
      return (id == RID_REGION) || (id == RID_DPERM) || (id == RID_IPERM);
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8
) (
   input  logic [3:0] prim_sel,
   input  logic [3:0] sec_sel,
   input  logic [2:0] op1,
   input  logic [2:0] op2,
   output reg_id_e    id,
   output logic [2:0] region_idx
);
   localparam logic [3:0] REGION_LIMIT = 4'(NUM_REGIONS);

   logic op1_zero, sec_zero, op2_zero;
   assign op1_zero   = (op1 == 3'd0);
   assign op2_zero   = (op2 == 3'd0);
   assign sec_zero   = (sec_sel == 4'd0);
   assign region_idx = sec_sel[2:0];

   always_comb begin
      id = RID_NONE;
      case (prim_sel)
         4'd0: if (op1_zero && sec_zero) begin
            case (op2)
               3'd1:    id = RID_CTYPE;
               3'd2:    id = RID_TCMSZ;
               default: id = RID_ID;
            endcase
         end
         4'd1: if (op1_zero && op2_zero && sec_zero) id = RID_CTRL;
         4'd2: if (op1_zero && sec_zero) begin
            case (op2)
               3'd0:    id = RID_DCCFG;
               3'd1:    id = RID_ICCFG;
               default: id = RID_NONE;
            endcase
         end
         4'd3: if (op1_zero && op2_zero && sec_zero) id = RID_WBUF;
         4'd5: if (op1_zero && sec_zero) begin
            case (op2)
               3'd2:    id = RID_DPERM;
               3'd3:    id = RID_IPERM;
               default: id = RID_NONE;
            endcase
         end
         4'd6: if (op1_zero && op2_zero && (sec_sel < REGION_LIMIT)) id = RID_REGION;
         4'd7: if (op1_zero && sec_zero && (op2 == 3'd4)) id = RID_WFI;
         4'd9: if (op1_zero) begin
            case ({sec_sel, op2})
               {4'd0, 3'd0}: id = RID_DLOCK;
               {4'd0, 3'd1}: id = RID_ILOCK;
               {4'd1, 3'd0}: id = RID_DTCM;
               {4'd1, 3'd1}: id = RID_ITCM;
               default:      id = RID_NONE;
            endcase
         end
         default: id = RID_NONE;
      endcase
   end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       NUM_REGIONS = 8,
   parameter logic [DATA_W-1:0] ID_CODE     = DEF_ID_CODE,
   parameter logic [DATA_W-1:0] CACHE_TYPE  = DEF_CACHE_TYPE,
   parameter logic [DATA_W-1:0] TCM_SIZE    = DEF_TCM_SIZE,
   parameter logic [DATA_W-1:0] PERM_RESET  = DEF_PERM,
   parameter logic [DATA_W-1:0] ITCM_RESET  = DEF_ITCM,
   parameter logic [DATA_W-1:0] DTCM_RESET  = DEF_DTCM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_id_e           id,
   input  logic [2:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] dtcm_q,
   output logic              upd_pulse
);
   logic [DATA_W-1:0] dccfg_q, iccfg_q, wbuf_q, dperm_q, iperm_q;
   logic [DATA_W-1:0] dlock_q, ilock_q, itcm_q;
   logic [DATA_W-1:0] region_q [NUM_REGIONS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         dccfg_q <= '0;
         iccfg_q <= '0;
         wbuf_q  <= '0;
         dperm_q <= PERM_RESET;
         iperm_q <= PERM_RESET;
         dlock_q <= '0;
         ilock_q <= '0;
         dtcm_q  <= DTCM_RESET;
         itcm_q  <= ITCM_RESET;
      end else if (wr_en) begin
         case (id)
            RID_CTRL:  ctrl_q  <= wdata;
            RID_DCCFG: dccfg_q <= wdata;
            RID_ICCFG: iccfg_q <= wdata;
            RID_WBUF:  wbuf_q  <= wdata;
            RID_DPERM: dperm_q <= wdata;
            RID_IPERM: iperm_q <= wdata;
            RID_DLOCK: dlock_q <= wdata;
            RID_ILOCK: ilock_q <= wdata;
            RID_DTCM:  dtcm_q  <= wdata;
            RID_ITCM:  itcm_q  <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      logic [DATA_W-1:0] desc_r;
      always_ff @(posedge clk) begin
         if (!rst_n)
            desc_r <= '0;
         else if (wr_en && (id == RID_REGION) && (idx == 3'(g)))
            desc_r <= wdata;
      end
      assign region_q[g] = desc_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) upd_pulse <= 1'b0;
      else        upd_pulse <= wr_en && id_protection(id);
   end

   always_comb begin
      rd_data = '0;
      case (id)
         RID_ID:     rd_data = ID_CODE;
         RID_CTYPE:  rd_data = CACHE_TYPE;
         RID_TCMSZ:  rd_data = TCM_SIZE;
         RID_CTRL:   rd_data = ctrl_q;
         RID_DCCFG:  rd_data = dccfg_q;
         RID_ICCFG:  rd_data = iccfg_q;
         RID_WBUF:   rd_data = wbuf_q;
         RID_DPERM:  rd_data = dperm_q;
         RID_IPERM:  rd_data = iperm_q;
         RID_DLOCK:  rd_data = dlock_q;
         RID_ILOCK:  rd_data = ilock_q;
         RID_DTCM:   rd_data = dtcm_q;
         RID_ITCM:   rd_data = itcm_q;
         RID_REGION: begin
            for (int i = 0; i < NUM_REGIONS; i++)
               if (idx == 3'(i)) rd_data = region_q[i];
         end
         default: rd_data = '0;
      endcase
   end

   // R6: a region write leaves every other descriptor untouched
   assert_region_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (id == RID_REGION) && (idx != 3'd0)) |=> $stable(region_q[0]));

endmodule

// File: rtl/sysctl_sideband.sv
module sysctl_sideband #(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       RW_BIT     = 7,
   parameter int unsigned       VEC_BIT    = 13,
   parameter int unsigned       STATE_BIT  = 15,
   parameter int unsigned       TCM_ALIGN  = 6,
   parameter logic [DATA_W-1:0] VEC_HIGH   = 32'h0FFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic [DATA_W-1:0] dtcm_q,
   input  logic              wfi_set,
   input  logic              irq,
   output logic              ctl_rw_mode,
   output logic [DATA_W-1:0] vec_base,
   output logic              state_load_en,
   output logic [DATA_W-1:0] dtcm_base,
   output logic [DATA_W-1:0] itcm_base,
   output logic              halt_req,
   output logic              irq_master_en
);
   localparam logic [DATA_W-1:0] TCM_MASK = ~((DATA_W'(1) << TCM_ALIGN) - DATA_W'(1));

   assign ctl_rw_mode   = ctrl_q[RW_BIT];
   assign vec_base      = ctrl_q[VEC_BIT] ? VEC_HIGH : '0;
   assign state_load_en = ~ctrl_q[STATE_BIT];
   assign dtcm_base     = dtcm_q & TCM_MASK;
   assign itcm_base     = '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_req      <= 1'b0;
         irq_master_en <= 1'b0;
      end else if (wfi_set) begin
         halt_req      <= 1'b1;
         irq_master_en <= 1'b1;
      end else if (halt_req && irq) begin
         halt_req      <= 1'b0;
      end
   end

   assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && !irq) |=> halt_req);
   assert_halt_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && irq && !wfi_set) |=> !halt_req);
   assert_wfi_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wfi_set |=> (halt_req && irq_master_en));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned RW_BIT      = 7,
   parameter int unsigned VEC_BIT     = 13,
   parameter int unsigned STATE_BIT   = 15,
   parameter int unsigned TCM_ALIGN   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              user_mode,
   input  logic [3:0]        prim_sel,
   input  logic [3:0]        sec_sel,
   input  logic [2:0]        op1,
   input  logic [2:0]        op2,
   input  logic [DATA_W-1:0] wdata,
   input  logic              irq,
   output logic              accept,
   output logic [DATA_W-1:0] rdata,
   output logic              ctl_rw_mode,
   output logic [DATA_W-1:0] vec_base,
   output logic              state_load_en,
   output logic [DATA_W-1:0] dtcm_base,
   output logic [DATA_W-1:0] itcm_base,
   output logic              halt_req,
   output logic              irq_master_en,
   output logic              prot_update
);
   if (DATA_W != 32) begin : g_bad_width
      $error("sysctl_regfile: DATA_W must be 32");
   end
   if (NUM_REGIONS < 1 || NUM_REGIONS > 8) begin : g_bad_regions
      $error("sysctl_regfile: NUM_REGIONS must be 1..8");
   end
   if (RW_BIT >= DATA_W || VEC_BIT >= DATA_W || STATE_BIT >= DATA_W || TCM_ALIGN >= DATA_W) begin : g_bad_bits
      $error("sysctl_regfile: bit positions exceed DATA_W");
   end

   reg_id_e           dec_id;
   logic [2:0]        dec_idx;
   logic              dir_ok, wr_en, wfi_set;
   logic [DATA_W-1:0] store_rd, ctrl_q, dtcm_q;

   sysctl_decode #(.NUM_REGIONS(NUM_REGIONS)) u_decode (
      .prim_sel   (prim_sel),
      .sec_sel    (sec_sel),
      .op1        (op1),
      .op2        (op2),
      .id         (dec_id),
      .region_idx (dec_idx)
   );

   assign dir_ok  = req_write ? !id_read_only(dec_id) : !id_write_only(dec_id);
   assign accept  = req_valid && !user_mode && (dec_id != RID_NONE) && dir_ok;
   assign wr_en   = accept && req_write;
   assign wfi_set = wr_en && (dec_id == RID_WFI);
   assign rdata   = (accept && !req_write) ? store_rd : '0;

   sysctl_store #(
      .DATA_W      (DATA_W),
      .NUM_REGIONS (NUM_REGIONS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .id        (dec_id),
      .idx       (dec_idx),
      .wdata     (wdata),
      .rd_data   (store_rd),
      .ctrl_q    (ctrl_q),
      .dtcm_q    (dtcm_q),
      .upd_pulse (prot_update)
   );

   sysctl_sideband #(
      .DATA_W    (DATA_W),
      .RW_BIT    (RW_BIT),
      .VEC_BIT   (VEC_BIT),
      .STATE_BIT (STATE_BIT),
      .TCM_ALIGN (TCM_ALIGN),
      .VEC_HIGH  (DATA_W'(DEF_VEC_HIGH))
   ) u_sideband (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctrl_q        (ctrl_q),
      .dtcm_q        (dtcm_q),
      .wfi_set       (wfi_set),
      .irq           (irq),
      .ctl_rw_mode   (ctl_rw_mode),
      .vec_base      (vec_base),
      .state_load_en (state_load_en),
      .dtcm_base     (dtcm_base),
      .itcm_base     (itcm_base),
      .halt_req      (halt_req),
      .irq_master_en (irq_master_en)
   );

   assert_user_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> !accept);
   assert_id_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (prim_sel == 4'd0)) |-> !accept);
   assert_user_no_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && user_mode) |=> $stable(ctl_rw_mode) && $stable(vec_base));
   assert_strobe_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      prot_update |-> $past(accept && req_write && ((prim_sel == 4'd5) || (prim_sel == 4'd6))));

endmodule

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/100ps
module sysctl_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, user_mode = 1'b0, irq = 1'b0;
   logic [3:0]  prim_sel = '0, sec_sel = '0;
   logic [2:0]  op1 = '0, op2 = '0;
   logic [31:0] wdata = '0;
   logic        accept, ctl_rw_mode, state_load_en, halt_req, irq_master_en, prot_update;
   logic [31:0] rdata, vec_base, dtcm_base, itcm_base;

   always #2.5 clk = ~clk;

   sysctl_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .user_mode(user_mode), .prim_sel(prim_sel), .sec_sel(sec_sel), .op1(op1), .op2(op2),
      .wdata(wdata), .irq(irq), .accept(accept), .rdata(rdata), .ctl_rw_mode(ctl_rw_mode),
      .vec_base(vec_base), .state_load_en(state_load_en), .dtcm_base(dtcm_base),
      .itcm_base(itcm_base), .halt_req(halt_req), .irq_master_en(irq_master_en),
      .prot_update(prot_update)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   logic [31:0] m_ctrl, m_dcc, m_icc, m_wb, m_dperm, m_iperm, m_dl, m_il, m_dtcm, m_itcm;
   logic [31:0] m_reg [8];
   bit m_halt, m_ime, m_upd;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ctrl = 0; m_dcc = 0; m_icc = 0; m_wb = 0; m_dl = 0; m_il = 0;
      m_dperm = 32'h22222222; m_iperm = 32'h22222222;
      m_dtcm = 32'h0080000A; m_itcm = 32'h0000000C;
      foreach (m_reg[k]) m_reg[k] = 0;
      m_halt = 0; m_ime = 0; m_upd = 0;
   endtask

   // target codes: 1 ctrl 2 dcc 3 icc 4 wb 5 dperm 6 iperm 10+k region
   // 20 dlock 21 ilock 22 dtcm 23 itcm 30 wait 40 identification
   task automatic model_access(input bit v, w, u, input int p, s, o1, o2,
                               output bit acc, output logic [31:0] rd, output int tgt);
      logic [31:0] val = 0;
      bit ro = 0, wo = 0;
      acc = 0; rd = 0; tgt = 0;
      if (p == 0 && o1 == 0 && s == 0) begin
         tgt = 40; ro = 1;
         val = (o2 == 1) ? 32'h0F0D2112 : (o2 == 2) ? 32'h00140140 : 32'h41049460;
      end else if (p == 1 && o1 == 0 && o2 == 0 && s == 0) begin tgt = 1; val = m_ctrl; end
      else if (p == 3 && o1 == 0 && o2 == 0 && s == 0) begin tgt = 4; val = m_wb; end
      else if (p == 2 && o1 == 0 && s == 0 && o2 == 0) begin tgt = 2; val = m_dcc; end
      else if (p == 2 && o1 == 0 && s == 0 && o2 == 1) begin tgt = 3; val = m_icc; end
      else if (p == 5 && o1 == 0 && s == 0 && o2 == 2) begin tgt = 5; val = m_dperm; end
      else if (p == 5 && o1 == 0 && s == 0 && o2 == 3) begin tgt = 6; val = m_iperm; end
      else if (p == 6 && o1 == 0 && o2 == 0 && s < 8) begin tgt = 10 + s; val = m_reg[s]; end
      else if (p == 7 && o1 == 0 && s == 0 && o2 == 4) begin tgt = 30; wo = 1; end
      else if (p == 9 && o1 == 0 && s == 0 && o2 == 0) begin tgt = 20; val = m_dl; end
      else if (p == 9 && o1 == 0 && s == 0 && o2 == 1) begin tgt = 21; val = m_il; end
      else if (p == 9 && o1 == 0 && s == 1 && o2 == 0) begin tgt = 22; val = m_dtcm; end
      else if (p == 9 && o1 == 0 && s == 1 && o2 == 1) begin tgt = 23; val = m_itcm; end
      if (!v || u || tgt == 0 || (w && ro) || (!w && wo)) begin
         tgt = 0;
         return;
      end
      acc = 1;
      rd = w ? 32'h0 : val;
   endtask

   task automatic cmp_sideband();
      chk("R8", "ctl_rw_mode", {31'b0, ctl_rw_mode}, {31'b0, m_ctrl[7]});
      chk("R8", "vec_base", vec_base, m_ctrl[13] ? 32'h0FFF0000 : 32'h0);
      chk("R8", "state_load_en", {31'b0, state_load_en}, {31'b0, ~m_ctrl[15]});
      chk("R9", "dtcm_base", dtcm_base, m_dtcm & 32'hFFFFFFC0);
      chk("R9", "itcm_base", itcm_base, 32'h0);
      chk("R10", "halt_req", {31'b0, halt_req}, {31'b0, m_halt});
      chk("R10", "irq_master_en", {31'b0, irq_master_en}, {31'b0, m_ime});
      chk("R12", "prot_update", {31'b0, prot_update}, {31'b0, m_upd});
   endtask

   task automatic cyc(string tag, bit v, w, u, int p, s, o1, o2, logic [31:0] d, bit iq);
      bit acc; logic [31:0] rd; int tgt;
      req_valid = v; req_write = w; user_mode = u;
      prim_sel = 4'(p); sec_sel = 4'(s); op1 = 3'(o1); op2 = 3'(o2); wdata = d; irq = iq;
      #1;
      model_access(v, w, u, p, s, o1, o2, acc, rd, tgt);
      chk(tag, "accept", {31'b0, accept}, {31'b0, acc});
      chk(tag, "rdata", rdata, rd);
      @(posedge clk);
      m_upd = acc && w && (tgt == 5 || tgt == 6 || (tgt >= 10 && tgt < 18));
      if (acc && w) begin
         case (tgt)
            1: m_ctrl = d;  2: m_dcc = d;  3: m_icc = d;  4: m_wb = d;
            5: m_dperm = d; 6: m_iperm = d;
            20: m_dl = d; 21: m_il = d; 22: m_dtcm = d; 23: m_itcm = d;
            default: if (tgt >= 10 && tgt < 18) m_reg[tgt-10] = d;
         endcase
      end
      if (acc && w && tgt == 30) begin m_halt = 1; m_ime = 1; end
      else if (m_halt && iq) m_halt = 0;
      @(negedge clk);
      cmp_sideband();
   endtask

   task automatic rd(string tag, int p, s, o1, o2);
      cyc(tag, 1, 0, 0, p, s, o1, o2, 32'h0, 0);
   endtask
   task automatic wr(string tag, int p, s, o1, o2, logic [31:0] d);
      cyc(tag, 1, 1, 0, p, s, o1, o2, d, 0);
   endtask
   task automatic idle(string tag, bit iq);
      cyc(tag, 0, 0, 0, 0, 0, 0, 0, 32'h0, iq);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_sideband();                       // R3 reset state of side-band outputs
      // R3 reset register values
      rd("R3", 1, 0, 0, 0);  rd("R3", 5, 0, 0, 2); rd("R3", 5, 0, 0, 3);
      rd("R3", 9, 1, 0, 0);  rd("R3", 9, 1, 0, 1); rd("R3", 6, 3, 0, 0);
      // R2 identification reads and rejected write
      rd("R2", 0, 0, 0, 0); rd("R2", 0, 0, 0, 1); rd("R2", 0, 0, 0, 2); rd("R2", 0, 0, 0, 7);
      wr("R2", 0, 0, 0, 1, 32'hDEADBEEF); rd("R2", 0, 0, 0, 1);
      rd("R2", 0, 0, 1, 0); rd("R2", 0, 2, 0, 0);
      // R1 user mode
      cyc("R1", 1, 1, 1, 1, 0, 0, 0, 32'hFFFFFFFF, 0);
      cyc("R1", 1, 1, 1, 6, 2, 0, 0, 32'h12345679, 0);
      cyc("R1", 1, 0, 1, 0, 0, 0, 0, 32'h0, 0);
      rd("R1", 1, 0, 0, 0); rd("R1", 6, 2, 0, 0);
      // R8 control side effects, R4 decode
      wr("R8", 1, 0, 0, 0, 32'h0000A080); rd("R4", 1, 0, 0, 0);
      wr("R8", 1, 0, 0, 0, 32'h00002000);
      wr("R8", 1, 0, 0, 0, 32'h00008000);
      wr("R4", 1, 0, 0, 1, 32'h00000080); wr("R4", 1, 1, 0, 0, 32'h80);
      wr("R4", 1, 0, 2, 0, 32'h80); rd("R4", 1, 0, 0, 0);
      wr("R4", 3, 0, 0, 0, 32'h000000F5); rd("R4", 3, 0, 0, 0); rd("R4", 3, 0, 0, 3);
      // R5 cache config and permissions, R12 strobe
      wr("R5", 2, 0, 0, 0, 32'h11110000); wr("R5", 2, 0, 0, 1, 32'h00002222);
      rd("R5", 2, 0, 0, 0); rd("R5", 2, 0, 0, 1); rd("R5", 2, 0, 0, 2);
      wr("R12", 5, 0, 0, 2, 32'h33336666); idle("R12", 0);
      wr("R12", 5, 0, 0, 3, 32'h01234567); wr("R12", 5, 0, 0, 2, 32'h7);
      rd("R5", 5, 0, 0, 2); rd("R5", 5, 0, 0, 3); wr("R5", 5, 0, 0, 0, 32'h9); rd("R5", 5, 1, 0, 2);
      // R6 regions
      for (int k = 0; k < 8; k++) wr("R6", 6, k, 0, 0, 32'h1000_0001 + (k << 12));
      for (int k = 0; k < 8; k++) rd("R6", 6, k, 0, 0);
      wr("R6", 6, 8, 0, 0, 32'h5); wr("R6", 6, 1, 1, 0, 32'h5); wr("R6", 6, 1, 0, 1, 32'h5);
      rd("R6", 6, 1, 0, 0);
      // R7 locks and TCM, R9 bases
      wr("R7", 9, 0, 0, 0, 32'hAAAA0000); wr("R7", 9, 0, 0, 1, 32'h0000BBBB);
      rd("R7", 9, 0, 0, 0); rd("R7", 9, 0, 0, 1); rd("R7", 9, 0, 0, 2); rd("R7", 9, 2, 0, 0);
      rd("R7", 9, 1, 1, 0);
      wr("R9", 9, 1, 0, 0, 32'h12345678); rd("R9", 9, 1, 0, 0);
      wr("R9", 9, 1, 0, 1, 32'hFFFFFFFF); rd("R9", 9, 1, 0, 1);
      wr("R9", 9, 1, 0, 0, 32'h0000003F);
      // R10 wait for interrupt
      idle("R10", 1);
      rd("R10", 7, 0, 0, 4);
      wr("R10", 7, 0, 0, 4, 32'h0);
      idle("R10", 0); idle("R10", 0); rd("R10", 1, 0, 0, 0);
      idle("R10", 1); idle("R10", 0);
      cyc("R10", 1, 1, 0, 7, 0, 0, 4, 32'h0, 1); idle("R10", 0); idle("R10", 1);
      wr("R10", 7, 0, 0, 3, 32'h0); wr("R10", 7, 1, 0, 4, 32'h0);
      // R11 undecoded
      rd("R11", 4, 0, 0, 0); wr("R11", 4, 0, 0, 0, 32'h1); rd("R11", 8, 0, 0, 0);
      rd("R11", 15, 0, 0, 0); rd("R11", 10, 0, 0, 0); wr("R11", 13, 0, 0, 0, 32'h1);
      idle("R11", 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule